// File: doc/BRIEF.md
# Chained Descriptor Fetch Unit

This block walks a linked list of transfer descriptors held in an external dual-port memory and presents each one to a DMA engine as a set of decoded fields. A descriptor is four 32-bit words. The engine supplies a head index with a start pulse. The unit reads the four words of that descriptor one at a time over a request/valid read port whose latency is decided by the memory. It then raises a ready flag with the decoded fields. When the engine reports that the transfer is finished, the unit follows the link word to the next descriptor. It returns to idle after a descriptor whose last flag is set. Descriptor contents are used as found, with no checking.

The same memory is also reachable from a register-bus slave port. Slave writes use the write port, which needs no acknowledge, so a write never waits for a fetch. Slave reads share the read port with the engine. The engine has fixed priority on that port, and a four-word fetch that has started runs to the end before any slave read gets in. A slave read keeps its request and address asserted until the memory returns valid data.

Top module: `bdesc_fetch`

## Requirements
- R1: While reset is low and on the first cycle after it, mem_re_o, mem_we_o, sl_ack_o, chain_busy_o and desc_vld_o are all 0.
- R2: Fetching descriptor index i reads word addresses 4*i, 4*i+1, 4*i+2 and 4*i+3 in that order. At most one read is outstanding, and the next request is issued only after the previous data has returned.
- R3: Each engine word read raises mem_re_o for exactly one cycle, whatever the read latency, and the data is captured only in the cycle mem_rvld_i is high.
- R4: desc_vld_o rises only after all four words have arrived. The fields are decoded as follows: desc_src_o = word 0, desc_dst_o = word 1, desc_len_o = word 2 [15:0], desc_burst_o = word 2 [23:16], desc_attr_o = word 2 [30:24], desc_last_o = word 2 [31], and desc_link_o = word 3, whose low index bits give the next descriptor.
- R5: If xfer_done_i arrives while desc_vld_o is high and the last flag is 0, the unit drops desc_vld_o and fetches the descriptor named by the link word. If the last flag is 1, the unit goes idle, with chain_busy_o and desc_vld_o both 0.
- R6: chain_start_i has no effect while chain_busy_o is high. xfer_done_i has no effect while desc_vld_o is low.
- R7: A slave read holds mem_re_o high with a stable address from its first request cycle through the cycle mem_rvld_i returns. That is latency + 2 cycles in total. sl_ack_o then pulses for one cycle with the returned word on sl_rdata_o.
- R8: A slave write produces a single one-cycle mem_we_o pulse carrying the slave address and data, with sl_ack_o high in that same cycle, one clock after the request. This holds even while a fetch is in progress.
- R9: When an engine fetch and a slave read compete for the read port, the engine wins. A slave read requested during a fetch is issued only after all four descriptor words have been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_start_i | input | 1 | Start a chain at chain_head_i (pulse) |
| chain_head_i | input | IDX_W | Index of the first descriptor |
| xfer_done_i | input | 1 | Engine finished the current descriptor (pulse) |
| chain_busy_o | output | 1 | A chain is being fetched or held |
| desc_vld_o | output | 1 | Decoded descriptor fields are valid |
| desc_src_o | output | 32 | Source address (word 0) |
| desc_dst_o | output | 32 | Destination address (word 1) |
| desc_len_o | output | 16 | Transfer length |
| desc_burst_o | output | 8 | Maximum burst size |
| desc_attr_o | output | 7 | Opaque attribute bits for the engine |
| desc_last_o | output | 1 | End-of-chain flag |
| desc_link_o | output | 32 | Link word; low IDX_W bits are the next index |
| sl_req_i | input | 1 | Slave access request, held until acknowledged |
| sl_we_i | input | 1 | Slave access is a write |
| sl_addr_i | input | AW | Slave word address |
| sl_wdata_i | input | 32 | Slave write data |
| sl_ack_o | output | 1 | Slave access complete (pulse) |
| sl_rdata_o | output | 32 | Slave read data |
| mem_re_o | output | 1 | Memory read request |
| mem_raddr_o | output | AW | Memory read address |
| mem_rdata_i | input | 32 | Memory read data |
| mem_rvld_i | input | 1 | Memory read data valid |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | AW | Memory write address |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
The fetch path is run with a read latency of 1, 3 and 6 cycles, so that a design pacing its reads to a fixed delay, rather than to the valid strobe, fails. Chains of one descriptor and of three descriptors with non-sequential links separate link following from simple index increment, and a link to index 0 checks that a zero link is not mistaken for an end of chain. Pulses of start and done during a fetch show whether stray control inputs are ignored. Slave reads issued alone, slave reads issued in the same cycle as a chain start, and slave writes issued during a slow fetch tell apart held versus pulsed slave requests, engine priority, and whether writes are blocked by the read port.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int WSEL_W     = $clog2(DESC_WORDS);
  // word 2 layout
  localparam int LEN_LSB    = 0;
  localparam int LEN_W      = 16;
  localparam int BURST_LSB  = 16;
  localparam int BURST_W    = 8;
  localparam int ATTR_LSB   = 24;
  localparam int ATTR_W     = 7;
  localparam int LAST_BIT   = 31;
  // word order inside a descriptor
  localparam int W_SRC  = 0;
  localparam int W_DST  = 1;
  localparam int W_CTL  = 2;
  localparam int W_LINK = 3;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ENG  = 2'd1,
    RD_SL   = 2'd2
  } rd_own_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FETCH = 2'd1,
    CH_READY = 2'd2
  } chain_st_e;
endpackage

// File: rtl/bdf_chain_ctrl.sv
module bdf_chain_ctrl
  import bdf_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int AW    = IDX_W + WSEL_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [IDX_W-1:0]             head_i,
  input  logic                         xfer_done_i,
  input  logic                         rd_done_i,
  input  logic [WORD_W-1:0]            rd_data_i,
  output logic                         rd_req_o,
  output logic [AW-1:0]                rd_addr_o,
  output logic                         busy_o,
  output logic                         vld_o,
  output logic [DESC_WORDS*WORD_W-1:0] words_o
);
  chain_st_e         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [WORD_W-1:0] link_w;
  logic              last_w;

  localparam logic [WSEL_W-1:0] WSEL_END = WSEL_W'(DESC_WORDS - 1);

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q <= '0;
      end else if (st_q == CH_FETCH && rd_done_i && wsel_q == WSEL_W'(g)) begin
        w_q <= rd_data_i;
      end
    end
    assign words_o[g*WORD_W +: WORD_W] = w_q;
  end

  assign link_w = words_o[W_LINK*WORD_W +: WORD_W];
  assign last_w = words_o[W_CTL*WORD_W + LAST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_IDLE;
      idx_q  <= '0;
      wsel_q <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE: begin
          if (start_i) begin
            idx_q  <= head_i;
            wsel_q <= '0;
            st_q   <= CH_FETCH;
          end
        end
        CH_FETCH: begin
          if (rd_done_i) begin
            if (wsel_q == WSEL_END) st_q <= CH_READY;
            else                    wsel_q <= wsel_q + 1'b1;
          end
        end
        CH_READY: begin
          if (xfer_done_i) begin
            if (last_w) begin
              st_q <= CH_IDLE;
            end else begin
              idx_q  <= link_w[IDX_W-1:0];
              wsel_q <= '0;
              st_q   <= CH_FETCH;
            end
          end
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st_q == CH_FETCH);
  assign rd_addr_o = {idx_q, wsel_q};
  assign busy_o    = (st_q != CH_IDLE);
  assign vld_o     = (st_q == CH_READY);
endmodule

// File: rtl/bdf_rd_port.sv
module bdf_rd_port
  import bdf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eng_req_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic          sl_req_i,
  input  logic [AW-1:0] sl_addr_i,
  input  logic          mem_rvld_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_raddr_o,
  output logic          eng_done_o,
  output logic          sl_done_o,
  output rd_own_e       own_o
);
  rd_own_e       own_q;
  logic [AW-1:0] sl_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q     <= RD_IDLE;
      sl_addr_q <= '0;
    end else begin
      unique case (own_q)
        RD_IDLE: begin
          // engine has fixed priority
          if (eng_req_i) begin
            own_q <= RD_ENG;
          end else if (sl_req_i) begin
            own_q     <= RD_SL;
            sl_addr_q <= sl_addr_i;
          end
        end
        RD_ENG:  if (mem_rvld_i) own_q <= RD_IDLE;
        RD_SL:   if (mem_rvld_i) own_q <= RD_IDLE;
        default: own_q <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_re_o    = 1'b0;
    mem_raddr_o = eng_addr_i;
    unique case (own_q)
      RD_IDLE: begin
        if (eng_req_i) begin
          mem_re_o = 1'b1;
        end else if (sl_req_i) begin
          mem_re_o    = 1'b1;
          mem_raddr_o = sl_addr_i;
        end
      end
      RD_SL: begin
        mem_re_o    = 1'b1;
        mem_raddr_o = sl_addr_q;
      end
      default: ;
    endcase
  end

  assign eng_done_o = (own_q == RD_ENG) && mem_rvld_i;
  assign sl_done_o  = (own_q == RD_SL) && mem_rvld_i;
  assign own_o      = own_q;
endmodule

// File: rtl/bdf_slave_if.sv
module bdf_slave_if
  import bdf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sl_req_i,
  input  logic              sl_we_i,
  input  logic [AW-1:0]     sl_addr_i,
  input  logic [WORD_W-1:0] sl_wdata_i,
  output logic              sl_ack_o,
  output logic [WORD_W-1:0] sl_rdata_o,
  output logic              rd_req_o,
  input  logic              rd_done_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  logic ack_q;
  logic wr_go;

  // ack_q masks the request during the acknowledge cycle
  assign wr_go    = sl_req_i && sl_we_i && !ack_q;
  assign rd_req_o = sl_req_i && !sl_we_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q       <= 1'b0;
      sl_rdata_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_waddr_o <= '0;
      mem_wdata_o <= '0;
    end else begin
      ack_q    <= 1'b0;
      mem_we_o <= 1'b0;
      if (wr_go) begin
        mem_we_o    <= 1'b1;
        mem_waddr_o <= sl_addr_i;
        mem_wdata_o <= sl_wdata_i;
        ack_q       <= 1'b1;
      end
      if (rd_done_i) begin
        sl_rdata_o <= rd_data_i;
        ack_q      <= 1'b1;
      end
    end
  end

  assign sl_ack_o = ack_q;
endmodule

// File: rtl/bdesc_fetch.sv
module bdesc_fetch
  import bdf_pkg::*;
#(
  parameter int DESC_CNT = 256,
  parameter int IDX_W    = $clog2(DESC_CNT),
  parameter int AW       = IDX_W + WSEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chain_start_i,
  input  logic [IDX_W-1:0]     chain_head_i,
  input  logic                 xfer_done_i,
  output logic                 chain_busy_o,
  output logic                 desc_vld_o,
  output logic [WORD_W-1:0]    desc_src_o,
  output logic [WORD_W-1:0]    desc_dst_o,
  output logic [LEN_W-1:0]     desc_len_o,
  output logic [BURST_W-1:0]   desc_burst_o,
  output logic [ATTR_W-1:0]    desc_attr_o,
  output logic                 desc_last_o,
  output logic [WORD_W-1:0]    desc_link_o,
  input  logic                 sl_req_i,
  input  logic                 sl_we_i,
  input  logic [AW-1:0]        sl_addr_i,
  input  logic [WORD_W-1:0]    sl_wdata_i,
  output logic                 sl_ack_o,
  output logic [WORD_W-1:0]    sl_rdata_o,
  output logic                 mem_re_o,
  output logic [AW-1:0]        mem_raddr_o,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  input  logic                 mem_rvld_i,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_waddr_o,
  output logic [WORD_W-1:0]    mem_wdata_o
);
  logic                         eng_rd_req;
  logic [AW-1:0]                eng_rd_addr;
  logic                         eng_rd_done;
  logic                         sl_rd_req;
  logic                         sl_rd_done;
  rd_own_e                      rd_own;
  logic [DESC_WORDS*WORD_W-1:0] words;
  logic [WORD_W-1:0]            ctl_w;

  bdf_chain_ctrl #(.IDX_W(IDX_W), .AW(AW)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (chain_start_i),
    .head_i      (chain_head_i),
    .xfer_done_i (xfer_done_i),
    .rd_done_i   (eng_rd_done),
    .rd_data_i   (mem_rdata_i),
    .rd_req_o    (eng_rd_req),
    .rd_addr_o   (eng_rd_addr),
    .busy_o      (chain_busy_o),
    .vld_o       (desc_vld_o),
    .words_o     (words)
  );

  bdf_rd_port #(.AW(AW)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eng_req_i   (eng_rd_req),
    .eng_addr_i  (eng_rd_addr),
    .sl_req_i    (sl_rd_req),
    .sl_addr_i   (sl_addr_i),
    .mem_rvld_i  (mem_rvld_i),
    .mem_re_o    (mem_re_o),
    .mem_raddr_o (mem_raddr_o),
    .eng_done_o  (eng_rd_done),
    .sl_done_o   (sl_rd_done),
    .own_o       (rd_own)
  );

  bdf_slave_if #(.AW(AW)) u_sl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sl_req_i    (sl_req_i),
    .sl_we_i     (sl_we_i),
    .sl_addr_i   (sl_addr_i),
    .sl_wdata_i  (sl_wdata_i),
    .sl_ack_o    (sl_ack_o),
    .sl_rdata_o  (sl_rdata_o),
    .rd_req_o    (sl_rd_req),
    .rd_done_i   (sl_rd_done),
    .rd_data_i   (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_waddr_o (mem_waddr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign ctl_w        = words[W_CTL*WORD_W +: WORD_W];
  assign desc_src_o   = words[W_SRC*WORD_W +: WORD_W];
  assign desc_dst_o   = words[W_DST*WORD_W +: WORD_W];
  assign desc_link_o  = words[W_LINK*WORD_W +: WORD_W];
  assign desc_len_o   = ctl_w[LEN_LSB +: LEN_W];
  assign desc_burst_o = ctl_w[BURST_LSB +: BURST_W];
  assign desc_attr_o  = ctl_w[ATTR_LSB +: ATTR_W];
  assign desc_last_o  = ctl_w[LAST_BIT];
endmodule

// File: rtl/bdesc_fetch_chk.sv
module bdesc_fetch_chk
  import bdf_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_raddr_o,
  input logic          mem_rvld_i,
  input logic          mem_we_o,
  input logic          sl_ack_o,
  input logic          desc_vld_o,
  input logic          desc_last_o,
  input logic          xfer_done_i,
  input logic          chain_busy_o,
  input logic          eng_rd_req,
  input logic          sl_rd_req,
  input logic [1:0]    rd_own
);
  // R7
  sl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_own == RD_SL && !mem_rvld_i) |=> (mem_re_o && $stable(mem_raddr_o)));

  // R3
  eng_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_own == RD_ENG && !mem_rvld_i) |=> !mem_re_o);

  // R9
  eng_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_own == RD_IDLE && eng_rd_req && sl_rd_req) |=> (rd_own == RD_ENG));

  // R8
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R8
  wr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> sl_ack_o);

  // R4
  ready_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desc_vld_o) |-> $past(mem_rvld_i));

  // R5
  last_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_vld_o && desc_last_o && xfer_done_i) |=> (!chain_busy_o && !desc_vld_o));
endmodule

bind bdesc_fetch bdesc_fetch_chk #(.AW(AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_re_o     (mem_re_o),
  .mem_raddr_o  (mem_raddr_o),
  .mem_rvld_i   (mem_rvld_i),
  .mem_we_o     (mem_we_o),
  .sl_ack_o     (sl_ack_o),
  .desc_vld_o   (desc_vld_o),
  .desc_last_o  (desc_last_o),
  .xfer_done_i  (xfer_done_i),
  .chain_busy_o (chain_busy_o),
  .eng_rd_req   (eng_rd_req),
  .sl_rd_req    (sl_rd_req),
  .rd_own       (rd_own)
);

// File: tb/test_bdesc_fetch.sv
module test_bdesc_fetch;
  localparam int IDX_W = 8;
  localparam int AW    = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            chain_start = 1'b0;
  logic [IDX_W-1:0] chain_head = '0;
  logic            xfer_done = 1'b0;
  logic            chain_busy, desc_vld, desc_last;
  logic [31:0]     desc_src, desc_dst, desc_link;
  logic [15:0]     desc_len;
  logic [7:0]      desc_burst;
  logic [6:0]      desc_attr;
  logic            sl_req = 1'b0, sl_we = 1'b0;
  logic [AW-1:0]   sl_addr = '0;
  logic [31:0]     sl_wdata = '0;
  logic            sl_ack;
  logic [31:0]     sl_rdata;
  logic            mem_re, mem_we;
  logic [AW-1:0]   mem_raddr, mem_waddr;
  logic [31:0]     mem_wdata;
  logic [31:0]     m_rdata = '0;
  logic            m_rvld = 1'b0;

  always #5 clk = ~clk;

  bdesc_fetch i_bdesc_fetch (
    .clk_i(clk), .rst_ni(rst_n),
    .chain_start_i(chain_start), .chain_head_i(chain_head), .xfer_done_i(xfer_done),
    .chain_busy_o(chain_busy), .desc_vld_o(desc_vld),
    .desc_src_o(desc_src), .desc_dst_o(desc_dst), .desc_len_o(desc_len),
    .desc_burst_o(desc_burst), .desc_attr_o(desc_attr), .desc_last_o(desc_last),
    .desc_link_o(desc_link),
    .sl_req_i(sl_req), .sl_we_i(sl_we), .sl_addr_i(sl_addr), .sl_wdata_i(sl_wdata),
    .sl_ack_o(sl_ack), .sl_rdata_o(sl_rdata),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(m_rdata), .mem_rvld_i(m_rvld),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  // memory model with programmable latency
  logic [31:0]   mem [1024];
  logic          m_busy = 1'b0;
  logic [AW-1:0] m_addr = '0;
  int            m_cnt = 0;
  int            lat = 1;
  logic [AW-1:0] rlog [64];
  int            rlogn = 0;

  always @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    m_rvld <= 1'b0;
    if (m_busy) begin
      if (m_cnt <= 1) begin
        m_rvld  <= 1'b1;
        m_rdata <= mem[m_addr];
        m_busy  <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end else if (mem_re && !m_rvld) begin
      m_busy          <= 1'b1;
      m_addr          <= mem_raddr;
      m_cnt           <= lat;
      rlog[rlogn % 64] <= mem_raddr;
      rlogn           <= rlogn + 1;
    end
  end

  int re_cyc = 0;
  int we_cyc = 0;
  always @(negedge clk) begin
    if (mem_re) re_cyc <= re_cyc + 1;
    if (mem_we) we_cyc <= we_cyc + 1;
  end

  int  errors = 0;
  int  checks = 0;
  bit  done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkeq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic logic [31:0] mk_ctl(input logic [15:0] len, input logic [7:0] burst,
                                         input logic [6:0] attr, input logic last);
    return {last, attr, burst, len};
  endfunction

  task automatic sl_write(input logic [AW-1:0] a, input logic [31:0] d, output int n);
    @(negedge clk);
    sl_req = 1'b1; sl_we = 1'b1; sl_addr = a; sl_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!sl_ack && n < 50);
    sl_req = 1'b0; sl_we = 1'b0;
  endtask

  task automatic sl_read(input logic [AW-1:0] a, output logic [31:0] d, output int n);
    @(negedge clk);
    sl_req = 1'b1; sl_we = 1'b0; sl_addr = a;
    n = 0;
    do begin @(negedge clk); n++; end while (!sl_ack && n < 100);
    d = sl_rdata;
    sl_req = 1'b0;
  endtask

  task automatic load_desc(input int idx, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3);
    int n;
    sl_write(AW'(idx*4+0), w0, n);
    sl_write(AW'(idx*4+1), w1, n);
    sl_write(AW'(idx*4+2), w2, n);
    sl_write(AW'(idx*4+3), w3, n);
  endtask

  task automatic start_chain(input int head);
    @(negedge clk);
    chain_start = 1'b1; chain_head = IDX_W'(head);
    @(negedge clk);
    chain_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic wait_vld(input string req);
    int n = 0;
    while (!desc_vld && n < 500) begin @(negedge clk); n++; end
    chk(desc_vld, req, 0, 1);
  endtask

  task automatic chk_desc(input string req, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    chkeq({req, " src"}, desc_src, w0);
    chkeq({req, " dst"}, desc_dst, w1);
    chkeq({req, " len"}, desc_len, w2[15:0]);
    chkeq({req, " burst"}, desc_burst, w2[23:16]);
    chkeq({req, " attr"}, desc_attr, w2[30:24]);
    chkeq({req, " last"}, desc_last, w2[31]);
    chkeq({req, " link"}, desc_link, w3);
  endtask

  task automatic chk_addrs(input string req, input int base, input int idx);
    chkeq({req, " read count"}, rlogn - base, 4);
    for (int i = 0; i < 4; i++)
      chkeq({req, " read addr"}, rlog[(base + i) % 64], idx*4 + i);
  endtask

  // R1
  task automatic t_reset();
    chkeq("R1 re in reset", mem_re, 0);
    chkeq("R1 we in reset", mem_we, 0);
    chkeq("R1 ack in reset", sl_ack, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkeq("R1 busy", chain_busy, 0);
    chkeq("R1 vld", desc_vld, 0);
    chkeq("R1 re", mem_re, 0);
  endtask

  // R8: writes are one pulse, acked one clock after request
  task automatic t_slave_wr();
    int n, w0;
    logic [31:0] d;
    w0 = we_cyc;
    sl_write(10'd100, 32'hCAFE_0100, n);
    chkeq("R8 ack delay", n, 1);
    @(negedge clk);
    chkeq("R8 single pulse", we_cyc - w0, 1);
    lat = 2;
    sl_read(10'd100, d, n);
    chkeq("R8 stored data", d, 32'hCAFE_0100);
  endtask

  // R7: held read, one read issued, ack one cycle
  task automatic t_slave_rd();
    int n, r0, b0;
    logic [31:0] d;
    int unused;
    lat = 4;
    sl_write(10'd200, 32'h1234_5678, unused);
    r0 = re_cyc; b0 = rlogn;
    sl_read(10'd200, d, n);
    chkeq("R7 data", d, 32'h1234_5678);
    chkeq("R7 re held cycles", re_cyc - r0, lat + 2);
    chkeq("R7 one request", rlogn - b0, 1);
    chkeq("R7 addr", rlog[b0 % 64], 200);
    @(negedge clk);
    chkeq("R7 ack one cycle", sl_ack, 0);
  endtask

  // R2 R3 R4 R5 single descriptor
  task automatic t_single(input int l);
    int b, r0;
    logic [31:0] w2;
    lat = l;
    w2 = mk_ctl(16'h0040 + 16'(l), 8'h10, 7'h2A, 1'b1);
    load_desc(5, 32'hA000_0000 + l, 32'hB000_0000 + l, w2, 32'h0000_0011);
    b = rlogn; r0 = re_cyc;
    start_chain(5);
    chkeq("R4 not ready early", desc_vld, 0);
    wait_vld("R4 ready");
    chk_desc("R4", 32'hA000_0000 + l, 32'hB000_0000 + l, w2, 32'h0000_0011);
    chk_addrs("R2", b, 5);
    chkeq("R3 re pulse count", re_cyc - r0, 4);
    pulse_done();
    chkeq("R5 last idle busy", chain_busy, 0);
    chkeq("R5 last idle vld", desc_vld, 0);
  endtask

  // R5 link following, link to index 0 is not end
  task automatic t_chain();
    int b;
    logic [31:0] c2, c9, c0;
    lat = 3;
    c2 = mk_ctl(16'd100, 8'd4, 7'h01, 1'b0);
    c9 = mk_ctl(16'd200, 8'd8, 7'h02, 1'b0);
    c0 = mk_ctl(16'd300, 8'd16, 7'h03, 1'b1);
    load_desc(2, 32'h2000, 32'h2100, c2, 32'd9);
    load_desc(9, 32'h9000, 32'h9100, c9, 32'd0);
    load_desc(0, 32'h0500, 32'h0600, c0, 32'hFFFF_FF07);
    b = rlogn;
    start_chain(2);
    wait_vld("R5 first");
    chk_desc("R5 d2", 32'h2000, 32'h2100, c2, 32'd9);
    b = rlogn;
    pulse_done();
    chkeq("R5 vld drops", desc_vld, 0);
    chkeq("R5 still busy", chain_busy, 1);
    wait_vld("R5 second");
    chk_desc("R5 d9", 32'h9000, 32'h9100, c9, 32'd0);
    chk_addrs("R5 link9", b, 9);
    b = rlogn;
    pulse_done();
    wait_vld("R5 third");
    chk_desc("R5 d0", 32'h0500, 32'h0600, c0, 32'hFFFF_FF07);
    chk_addrs("R5 link0", b, 0);
    pulse_done();
    chkeq("R5 end busy", chain_busy, 0);
  endtask

  // R6 start and done ignored in the wrong state
  task automatic t_ignore();
    int b;
    logic [31:0] c7, c3;
    lat = 3;
    c7 = mk_ctl(16'd7, 8'd7, 7'h07, 1'b1);
    c3 = mk_ctl(16'd3, 8'd3, 7'h03, 1'b1);
    load_desc(7, 32'h7777, 32'h7070, c7, 32'h0);
    load_desc(3, 32'h3333, 32'h3030, c3, 32'h0);
    b = rlogn;
    start_chain(7);
    @(negedge clk);
    chain_start = 1'b1; chain_head = 8'd3; xfer_done = 1'b1;
    @(negedge clk);
    chain_start = 1'b0; xfer_done = 1'b0;
    wait_vld("R6 ready");
    chk_desc("R6 d7", 32'h7777, 32'h7070, c7, 32'h0);
    chk_addrs("R6 no restart", b, 7);
    start_chain(3);
    repeat (20) @(negedge clk);
    chkeq("R6 start while held", desc_src, 32'h7777);
    chkeq("R6 vld kept", desc_vld, 1);
    pulse_done();
    chkeq("R6 end", chain_busy, 0);
  endtask

  // R9 slave read in same cycle as fetch start waits for all four words
  task automatic t_prio();
    int b, n;
    logic [31:0] c4;
    int unused;
    lat = 2;
    c4 = mk_ctl(16'd44, 8'd4, 7'h04, 1'b1);
    load_desc(4, 32'h4444, 32'h4040, c4, 32'h0);
    sl_write(10'd300, 32'hBEEF_0300, unused);
    b = rlogn;
    @(negedge clk);
    chain_start = 1'b1; chain_head = 8'd4;
    @(negedge clk);
    chain_start = 1'b0;
    sl_req = 1'b1; sl_we = 1'b0; sl_addr = 10'd300;
    n = 0;
    do begin @(negedge clk); n++; end while (!sl_ack && n < 100);
    chkeq("R9 slave data", sl_rdata, 32'hBEEF_0300);
    sl_req = 1'b0;
    chkeq("R9 read count", rlogn - b, 5);
    for (int i = 0; i < 4; i++)
      chkeq("R9 engine first", rlog[(b + i) % 64], 16 + i);
    chkeq("R9 slave last", rlog[(b + 4) % 64], 300);
    wait_vld("R9 ready");
    pulse_done();
  endtask

  // R8 write not blocked by a slow fetch
  task automatic t_wr_during_fetch();
    int n;
    logic [31:0] c11, d;
    lat = 8;
    c11 = mk_ctl(16'd11, 8'd1, 7'h0B, 1'b1);
    load_desc(11, 32'hB1B1, 32'hB2B2, c11, 32'h0);
    start_chain(11);
    sl_write(10'd400, 32'h0400_0400, n);
    chkeq("R8 ack during fetch", n, 1);
    chkeq("R8 fetch still running", chain_busy && !desc_vld, 1);
    wait_vld("R8 fetch ready");
    chk_desc("R8 d11", 32'hB1B1, 32'hB2B2, c11, 32'h0);
    pulse_done();
    lat = 1;
    sl_read(10'd400, d, n);
    chkeq("R8 data during fetch", d, 32'h0400_0400);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_slave_wr();
    t_slave_rd();
    t_single(1);
    t_single(6);
    t_chain();
    t_ignore();
    t_prio();
    t_wr_during_fetch();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule